// File: doc/BRIEF.md
# Interruption Context Save Controller

This block performs the hardware side of a fast context switch when the processor accepts an interruption. In the cycle of the accept strobe it records a status word in an interruption status register and loads a forced status word with interrupts masked and queue tracking off. It also drops the current privilege to the most privileged level, copies seven fixed general registers into shadow copies, and may capture the faulting instruction word and fault address.

The recorded status word depends on the group of the interruption. Groups 1 to 3 record the word as it stood when the instruction began, and group 4 records the word after the instruction completed. The Q bit of the recorded word decides whether the instruction and address detail registers capture anything. Two-entry space and offset queues follow the front and back instruction addresses on every cycle in which the Q bit of the live status word is set. Once that bit is clear they hold the addresses of the two pending instructions.

Top module: `intr_ctx_save`

## Requirements
- R1: When `accept` is high and `grp` is 3 (group 4), `ipsw` holds the value of `psw_post` from that cycle on the next cycle.
- R2: When `accept` is high and `grp` is 0, 1 or 2 (groups 1 to 3), `ipsw` holds the value of `psw_pre` from that cycle on the next cycle.
- R3: On accept, `psw_new` is loaded with bit E_BIT (default 8) equal to `dflt_e`, bit M_BIT (default 4) set only when `vec` equals HPMC_VEC (default 1), and every other bit 0, so Q_BIT (default 3) is 0.
- R4: On accept, `priv` becomes 0. Reset leaves `priv` at PL_RESET (default 3).
- R5: On each clock edge at which bit Q_BIT of `psw_pre` is 1, the space and offset queues load the front and back addresses. When that bit is 0 they keep their values, even during an accept.
- R6: `iir` loads `instr` on accept only when the Q bit of the recorded status word (the one chosen under R1/R2) is 1 and `iir_en` is 1. Otherwise it holds.
- R7: `isr` and `ior` load `flt_space` and the full-width `flt_off` on accept only when that same Q bit is 1 and `addr_en` is 1. Otherwise they hold.
- R8: On accept, shadow slots 0 to 6 (slot k at bits k*DW) receive general registers 1, 8, 9, 16, 17, 24 and 25 in that order, with register i taken from `gr_file` bits i*DW.
- R9: Without `accept`, `ipsw`, `psw_new`, `priv`, `iir`, `isr`, `ior` and `shadow` keep their values.
- R10: After reset all registers are 0 except `priv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| accept | input | 1 | Interruption accepted this cycle |
| vec | input | VEC_W | Interruption number |
| grp | input | 2 | Group minus one (0..3) |
| psw_pre | input | PSW_W | Live status word at instruction start |
| psw_post | input | PSW_W | Status word after instruction execution |
| dflt_e | input | 1 | Default endian value |
| iir_en | input | 1 | Interruption has an associated instruction |
| addr_en | input | 1 | Interruption has an associated address |
| instr | input | DW | Interrupting instruction word |
| flt_space | input | SPW | Fault address space |
| flt_off | input | DW | Fault address offset |
| ia_sq_front | input | SPW | Front instruction space |
| ia_sq_back | input | SPW | Back instruction space |
| ia_oq_front | input | DW | Front instruction offset |
| ia_oq_back | input | DW | Back instruction offset |
| gr_file | input | NGR*DW | Flattened general registers |
| ipsw | output | PSW_W | Recorded status word |
| psw_new | output | PSW_W | Forced status word |
| priv | output | PL_W | Current privilege level |
| iir | output | DW | Captured instruction word |
| isr | output | SPW | Captured fault space |
| ior | output | DW | Captured fault offset |
| iiasq_front | output | SPW | Space queue front |
| iiasq_back | output | SPW | Space queue back |
| iiaoq_front | output | DW | Offset queue front |
| iiaoq_back | output | DW | Offset queue back |
| shadow | output | 7*DW | Shadow register copies |

## Verification
On every cycle the assertions check the choice of recorded status word by group, the forced status and privilege, queue freezing while Q is clear, the detail registers holding when their capture is gated off, and all state holding between accepts. The gate on the detail registers, combining the recorded Q bit with each enable, is swept in the bench across every group, both Q values of both status words, both enables, both endian values, and vectors that are and are not the high-priority machine check. The bench also covers the exact values captured, the mapping of shadow slots to registers, and queue tracking during idle cycles.

// File: rtl/intr_ctx_save.sv
module intr_ctx_save #(
  parameter int DW       = 32,
  parameter int SPW      = 16,
  parameter int PSW_W    = 32,
  parameter int NGR      = 32,
  parameter int VEC_W    = 5,
  parameter int Q_BIT    = 3,
  parameter int M_BIT    = 4,
  parameter int E_BIT    = 8,
  parameter int HPMC_VEC = 1,
  parameter int PL_W     = 2,
  parameter int PL_RESET = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic [VEC_W-1:0]   vec,
  input  logic [1:0]         grp,
  input  logic [PSW_W-1:0]   psw_pre,
  input  logic [PSW_W-1:0]   psw_post,
  input  logic               dflt_e,
  input  logic               iir_en,
  input  logic               addr_en,
  input  logic [DW-1:0]      instr,
  input  logic [SPW-1:0]     flt_space,
  input  logic [DW-1:0]      flt_off,
  input  logic [SPW-1:0]     ia_sq_front,
  input  logic [SPW-1:0]     ia_sq_back,
  input  logic [DW-1:0]      ia_oq_front,
  input  logic [DW-1:0]      ia_oq_back,
  input  logic [NGR*DW-1:0]  gr_file,
  output logic [PSW_W-1:0]   ipsw,
  output logic [PSW_W-1:0]   psw_new,
  output logic [PL_W-1:0]    priv,
  output logic [DW-1:0]      iir,
  output logic [SPW-1:0]     isr,
  output logic [DW-1:0]      ior,
  output logic [SPW-1:0]     iiasq_front,
  output logic [SPW-1:0]     iiasq_back,
  output logic [DW-1:0]      iiaoq_front,
  output logic [DW-1:0]      iiaoq_back,
  output logic [7*DW-1:0]    shadow
);

  localparam int NSHD = 7;
  localparam logic [1:0] GRP4 = 2'd3;

  logic [PSW_W-1:0] psw_sel;
  logic [PSW_W-1:0] psw_force;
  logic             q_saved;
  logic             q_live;

  assign psw_sel = (grp == GRP4) ? psw_post : psw_pre;
  assign q_saved = psw_sel[Q_BIT];
  assign q_live  = psw_pre[Q_BIT];

  always_comb begin
    psw_force        = '0;
    psw_force[E_BIT] = dflt_e;
    psw_force[M_BIT] = (vec == VEC_W'(HPMC_VEC));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ipsw    <= '0;
      psw_new <= '0;
      priv    <= PL_W'(PL_RESET);
    end else if (accept) begin
      ipsw    <= psw_sel;
      psw_new <= psw_force;
      priv    <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iir <= '0;
    end else if (accept && q_saved && iir_en) begin
      iir <= instr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr <= '0;
      ior <= '0;
    end else if (accept && q_saved && addr_en) begin
      isr <= flt_space;
      ior <= flt_off;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iiasq_front <= '0;
      iiasq_back  <= '0;
      iiaoq_front <= '0;
      iiaoq_back  <= '0;
    end else if (q_live) begin
      iiasq_front <= ia_sq_front;
      iiasq_back  <= ia_sq_back;
      iiaoq_front <= ia_oq_front;
      iiaoq_back  <= ia_oq_back;
    end
  end

  for (genvar k = 0; k < NSHD; k++) begin : g_shd
    localparam int GR_IDX = 8 * ((k + 1) / 2) + ((k + 1) % 2);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      shadow[k*DW +: DW] <= '0;
      else if (accept) shadow[k*DW +: DW] <= gr_file[GR_IDX*DW +: DW];
    end
  end

endmodule

// File: rtl/intr_ctx_save_chk.sv
module intr_ctx_save_chk #(
  parameter int DW       = 32,
  parameter int SPW      = 16,
  parameter int PSW_W    = 32,
  parameter int NGR      = 32,
  parameter int VEC_W    = 5,
  parameter int Q_BIT    = 3,
  parameter int M_BIT    = 4,
  parameter int E_BIT    = 8,
  parameter int HPMC_VEC = 1,
  parameter int PL_W     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic [VEC_W-1:0]  vec,
  input logic [1:0]        grp,
  input logic [PSW_W-1:0]  psw_pre,
  input logic [PSW_W-1:0]  psw_post,
  input logic              dflt_e,
  input logic              iir_en,
  input logic              addr_en,
  input logic [NGR*DW-1:0] gr_file,
  input logic [PSW_W-1:0]  ipsw,
  input logic [PSW_W-1:0]  psw_new,
  input logic [PL_W-1:0]   priv,
  input logic [DW-1:0]     iir,
  input logic [SPW-1:0]    isr,
  input logic [DW-1:0]     ior,
  input logic [SPW-1:0]    iiasq_front,
  input logic [SPW-1:0]    iiasq_back,
  input logic [DW-1:0]     iiaoq_front,
  input logic [DW-1:0]     iiaoq_back,
  input logic [7*DW-1:0]   shadow
);

  logic q_rec;
  assign q_rec = (grp == 2'd3) ? psw_post[Q_BIT] : psw_pre[Q_BIT];

  // R1
  grp4_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && grp == 2'd3) |=> ipsw == $past(psw_post));

  // R2
  grp123_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && grp != 2'd3) |=> ipsw == $past(psw_pre));

  // R3
  new_psw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (psw_new[E_BIT] == $past(dflt_e)) && !psw_new[Q_BIT] &&
               (psw_new[M_BIT] == ($past(vec) == VEC_W'(HPMC_VEC))) &&
               ($countones(psw_new) == (int'(psw_new[E_BIT]) + int'(psw_new[M_BIT]))));

  // R4
  priv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> priv == '0);

  // R5
  queue_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !psw_pre[Q_BIT] |=> $stable(iiasq_front) && $stable(iiasq_back) &&
                        $stable(iiaoq_front) && $stable(iiaoq_back));

  // R6
  iir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && q_rec && iir_en) |=> $stable(iir));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && q_rec && addr_en) |=> $stable(isr) && $stable(ior));

  // R8
  shadow_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> shadow[0 +: DW] == $past(gr_file[DW +: DW]) &&
               shadow[6*DW +: DW] == $past(gr_file[25*DW +: DW]));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(ipsw) && $stable(psw_new) && $stable(priv) && $stable(shadow));

endmodule

bind intr_ctx_save intr_ctx_save_chk #(
  .DW(DW), .SPW(SPW), .PSW_W(PSW_W), .NGR(NGR), .VEC_W(VEC_W),
  .Q_BIT(Q_BIT), .M_BIT(M_BIT), .E_BIT(E_BIT), .HPMC_VEC(HPMC_VEC), .PL_W(PL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .vec(vec), .grp(grp),
  .psw_pre(psw_pre), .psw_post(psw_post), .dflt_e(dflt_e),
  .iir_en(iir_en), .addr_en(addr_en), .gr_file(gr_file),
  .ipsw(ipsw), .psw_new(psw_new), .priv(priv), .iir(iir), .isr(isr), .ior(ior),
  .iiasq_front(iiasq_front), .iiasq_back(iiasq_back),
  .iiaoq_front(iiaoq_front), .iiaoq_back(iiaoq_back), .shadow(shadow)
);

// File: tb/intr_ctx_save_tb.sv
module intr_ctx_save_tb;
  localparam int DW = 32, SPW = 16, PW = 32, NGR = 32;

  logic clk = 0, rst_n = 0, accept = 0, dflt_e = 0, iir_en = 0, addr_en = 0;
  logic [4:0] vec = '0;
  logic [1:0] grp = '0;
  logic [PW-1:0] psw_pre = '0, psw_post = '0;
  logic [DW-1:0] instr = '0, flt_off = '0, ia_oq_front = '0, ia_oq_back = '0;
  logic [SPW-1:0] flt_space = '0, ia_sq_front = '0, ia_sq_back = '0;
  logic [NGR*DW-1:0] gr_file = '0;
  logic [PW-1:0] ipsw, psw_new;
  logic [1:0] priv;
  logic [DW-1:0] iir, ior, iiaoq_front, iiaoq_back;
  logic [SPW-1:0] isr, iiasq_front, iiasq_back;
  logic [7*DW-1:0] shadow;

  int checks = 0, errors = 0;

  logic [PW-1:0] e_ipsw = '0, e_psw = '0;
  logic [1:0] e_priv = 2'd3;
  logic [DW-1:0] e_iir = '0, e_ior = '0, e_oqf = '0, e_oqb = '0;
  logic [SPW-1:0] e_isr = '0, e_sqf = '0, e_sqb = '0;
  logic [7*DW-1:0] e_shd = '0;

  intr_ctx_save u_dut (
    .clk(clk), .rst_n(rst_n), .accept(accept), .vec(vec), .grp(grp),
    .psw_pre(psw_pre), .psw_post(psw_post), .dflt_e(dflt_e),
    .iir_en(iir_en), .addr_en(addr_en), .instr(instr),
    .flt_space(flt_space), .flt_off(flt_off),
    .ia_sq_front(ia_sq_front), .ia_sq_back(ia_sq_back),
    .ia_oq_front(ia_oq_front), .ia_oq_back(ia_oq_back), .gr_file(gr_file),
    .ipsw(ipsw), .psw_new(psw_new), .priv(priv), .iir(iir), .isr(isr), .ior(ior),
    .iiasq_front(iiasq_front), .iiasq_back(iiasq_back),
    .iiaoq_front(iiaoq_front), .iiaoq_back(iiaoq_back), .shadow(shadow)
  );

  always #5 clk = ~clk;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check({req, " ipsw"}, 64'(ipsw), 64'(e_ipsw));
    check({req, " psw_new"}, 64'(psw_new), 64'(e_psw));
    check({req, " priv"}, 64'(priv), 64'(e_priv));
    check({req, " R6 iir"}, 64'(iir), 64'(e_iir));
    check({req, " R7 isr"}, 64'(isr), 64'(e_isr));
    check({req, " R7 ior"}, 64'(ior), 64'(e_ior));
    check({req, " R5 sq"}, {32'(iiasq_front), 32'(iiasq_back)}, {32'(e_sqf), 32'(e_sqb)});
    check({req, " R5 oq"}, {iiaoq_front, iiaoq_back}, {e_oqf, e_oqb});
    for (int k = 0; k < 7; k++)
      check({req, " R8 shadow"}, 64'(shadow[k*DW +: DW]), 64'(e_shd[k*DW +: DW]));
  endtask

  task automatic drive(int n, bit acc);
    accept      = acc;
    grp         = 2'(n);
    vec         = n[7] ? 5'd1 : 5'(2 + n % 20);
    dflt_e      = n[6];
    iir_en      = n[4];
    addr_en     = n[5];
    psw_pre     = (32'hA5C3_0F00 ^ 32'(n * 32'h9E37)) & ~32'h8;
    psw_pre[3]  = acc ? n[2] : (n[0] ^ n[3]);
    psw_post    = (32'h5A3C_F0F0 ^ 32'(n * 32'h1357)) & ~32'h8;
    psw_post[3] = n[3];
    instr       = 32'hC0DE_0000 + 32'(n * 7);
    flt_space   = 16'h4000 + 16'(n);
    flt_off     = 32'hF000_0001 + 32'(n * 32'h0001_0003);
    ia_sq_front = 16'h1000 + 16'(n * 3);
    ia_sq_back  = 16'h2000 + 16'(n * 5);
    ia_oq_front = 32'h0000_0100 + 32'(n * 8);
    ia_oq_back  = 32'h0000_0104 + 32'(n * 8);
    for (int i = 0; i < NGR; i++) gr_file[i*DW +: DW] = 32'(i) * 32'h0101_0101 + 32'(n * 3 + (acc ? 0 : 77));
  endtask

  task automatic model();
    logic q;
    if (psw_pre[3]) begin
      e_sqf = ia_sq_front; e_sqb = ia_sq_back; e_oqf = ia_oq_front; e_oqb = ia_oq_back;
    end
    if (accept) begin
      e_ipsw = (grp == 2'd3) ? psw_post : psw_pre;
      q = e_ipsw[3];
      e_psw = '0;
      e_psw[8] = dflt_e;
      e_psw[4] = (vec == 5'd1);
      e_priv = 2'd0;
      if (q && iir_en) e_iir = instr;
      if (q && addr_en) begin e_isr = flt_space; e_ior = flt_off; end
      begin
        int idx[7] = '{1, 8, 9, 16, 17, 24, 25};
        for (int k = 0; k < 7; k++) e_shd[k*DW +: DW] = gr_file[idx[k]*DW +: DW];
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state, R4 reset privilege
    check_all("R10 R4 reset");
    rst_n = 1;
    @(negedge clk);
    check_all("R10 after release");
    for (int n = 0; n < 256; n++) begin
      drive(n, 1'b1);
      model();
      @(negedge clk);
      check_all((n[1:0] == 2'd3) ? "R1 R3 R4 accept" : "R2 R3 R4 accept");
      drive(n, 1'b0);
      model();
      @(negedge clk);
      check_all("R9 R5 idle");
    end
    accept = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule